// File: doc/BRIEF.md
# Two-Slot Transmit Request Queue

This block sits on the register side of an Ethernet transmitter and tracks up to two transmit requests for the DMA engine: the frame now being sent and one frame waiting behind it. Software first stores a buffer address, then writes a byte length together with a flag that suppresses CRC generation. That length write commits the request. A length of zero commits nothing.

When the transmitter is free, a committed request starts at once. The block pulses a start request and presents the address, length and no-CRC flag of the active frame. When the transmitter is busy, the request is held in the waiting slot. When the transmitter reports the end of a frame, the waiting request moves into the active slot and is started in the same step.

The block keeps four status flags for software. A slot-free flag tells software that it may write the next request. An idle flag shows that no frame is active. Two sticky flags record an overrun and a collision, and each is cleared by a write-one pulse.

Top module: `txq_ctrl`

## Requirements
- R1: After reset, `tx_idle` and `slot_free` are 1, and `ovr_flag`, `col_flag` and `start_req` are 0.
- R2: A non-zero length write while no frame is active makes `start_req` high for exactly the following cycle. In that cycle `start_addr` holds the most recently accepted address, and `start_len` and `start_nocrc` hold the written values. `tx_idle` drops in the same cycle.
- R3: A length write of zero starts nothing, leaves `tx_idle` unchanged and does not set `ovr_flag`.
- R4: A non-zero length write while one frame is active is held as pending. `slot_free` drops the next cycle, and no `start_req` is issued for the pending frame before the active one completes.
- R5: A `tx_done` pulse while a frame is pending promotes the pending frame. `start_req` is high the next cycle with the pending address, length and no-CRC flag, and `slot_free` returns to 1.
- R6: A `tx_done` pulse with no pending frame makes `tx_idle` 1 the next cycle. `tx_done` while idle has no effect.
- R7: An address or length write while `slot_free` is 0 sets `ovr_flag` the next cycle. The write is discarded, and the address and length of both queued frames are unchanged.
- R8: `clr_ovr` clears `ovr_flag`. If an overrun write and `clr_ovr` occur in the same cycle, `ovr_flag` stays 1.
- R9: `tx_col` while a frame is active sets `col_flag` the next cycle. `tx_col` while idle is ignored. `clr_col` clears `col_flag`.
- R10: `rd_len` returns the last accepted non-zero length and does not change while frames are transmitted. `rd_nocrc` returns the no-CRC flag of the active frame, not of the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr_en | input | 1 | Address register write strobe |
| wr_addr_data | input | ADDR_W | Buffer address being written |
| wr_len_en | input | 1 | Length register write strobe |
| wr_len_data | input | LEN_W | Frame byte count being written |
| wr_nocrc | input | 1 | No-CRC flag written with the length |
| clr_ovr | input | 1 | Write-one-to-clear for the overrun flag |
| clr_col | input | 1 | Write-one-to-clear for the collision flag |
| tx_done | input | 1 | Transmitter finished the active frame |
| tx_col | input | 1 | Collision seen by the transmitter |
| start_req | output | 1 | One-cycle start pulse toward the transmitter |
| start_addr | output | ADDR_W | Address of the active frame |
| start_len | output | LEN_W | Length of the active frame |
| start_nocrc | output | 1 | No-CRC flag of the active frame |
| slot_free | output | 1 | A queue slot can take a new request |
| tx_idle | output | 1 | No frame active |
| ovr_flag | output | 1 | Sticky overrun flag |
| col_flag | output | 1 | Sticky collision flag |
| rd_len | output | LEN_W | Read-back of the programmed length |
| rd_nocrc | output | 1 | Read-back of the active frame's no-CRC flag |

## Verification
The hardest situation to reach is a write arriving while both slots are full, followed by a promotion. The bench has to show that the discarded address never reaches `start_addr`, and that the discarded length never reaches `start_len` or `rd_len`. The stimulus fills both slots, writes a new address and length into the full queue, and then completes the active frame. It then launches a later frame by writing only a length. That later frame must still carry the address accepted before the overrun. A second sequence lines up an overrun write and the overrun clear in the same cycle, to check that setting the flag wins over clearing it.

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr_en,
  input  logic [ADDR_W-1:0] wr_addr_data,
  input  logic              wr_len_en,
  input  logic [LEN_W-1:0]  wr_len_data,
  input  logic              wr_nocrc,
  input  logic              clr_ovr,
  input  logic              clr_col,
  input  logic              tx_done,
  input  logic              tx_col,
  output logic              start_req,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  start_len,
  output logic              start_nocrc,
  output logic              slot_free,
  output logic              tx_idle,
  output logic              ovr_flag,
  output logic              col_flag,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_nocrc
);

  logic              act_v, pend_v;
  logic [ADDR_W-1:0] stage_addr, act_addr, pend_addr;
  logic [LEN_W-1:0]  act_len, pend_len, last_len;
  logic              act_nc, pend_nc;
  logic              sreq_q, ovr_q, col_q;

  assign slot_free = !(act_v && pend_v);

  wire              bad_wr   = (wr_addr_en || wr_len_en) && !slot_free;
  wire              commit   = wr_len_en && slot_free && (wr_len_data != '0);
  wire              finish   = tx_done && act_v;
  wire [ADDR_W-1:0] new_addr = (wr_addr_en && slot_free) ? wr_addr_data : stage_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_v      <= 1'b0;
      pend_v     <= 1'b0;
      stage_addr <= '0;
      act_addr   <= '0;
      pend_addr  <= '0;
      act_len    <= '0;
      pend_len   <= '0;
      last_len   <= '0;
      act_nc     <= 1'b0;
      pend_nc    <= 1'b0;
      sreq_q     <= 1'b0;
      ovr_q      <= 1'b0;
      col_q      <= 1'b0;
    end else begin
      sreq_q <= 1'b0;
      if (wr_addr_en && slot_free) stage_addr <= wr_addr_data;
      if (commit) last_len <= wr_len_data;
      if (finish) begin
        if (pend_v) begin
          act_addr <= pend_addr;
          act_len  <= pend_len;
          act_nc   <= pend_nc;
          pend_v   <= 1'b0;
          sreq_q   <= 1'b1;
        end else if (commit) begin
          act_addr <= new_addr;
          act_len  <= wr_len_data;
          act_nc   <= wr_nocrc;
          sreq_q   <= 1'b1;
        end else begin
          act_v <= 1'b0;
        end
      end else if (commit) begin
        if (!act_v) begin
          act_addr <= new_addr;
          act_len  <= wr_len_data;
          act_nc   <= wr_nocrc;
          act_v    <= 1'b1;
          sreq_q   <= 1'b1;
        end else begin
          pend_addr <= new_addr;
          pend_len  <= wr_len_data;
          pend_nc   <= wr_nocrc;
          pend_v    <= 1'b1;
        end
      end
      ovr_q <= bad_wr || (ovr_q && !clr_ovr);
      col_q <= (tx_col && act_v) || (col_q && !clr_col);
    end
  end

  assign start_req   = sreq_q;
  assign start_addr  = act_addr;
  assign start_len   = act_len;
  assign start_nocrc = act_nc;
  assign tx_idle     = !act_v;
  assign ovr_flag    = ovr_q;
  assign col_flag    = col_q;
  assign rd_len      = last_len;
  assign rd_nocrc    = act_nc;

endmodule

// File: rtl/txq_ctrl_chk.sv
module txq_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_addr_en,
  input logic              wr_len_en,
  input logic [LEN_W-1:0]  wr_len_data,
  input logic              tx_done,
  input logic              tx_col,
  input logic              clr_ovr,
  input logic              start_req,
  input logic [ADDR_W-1:0] start_addr,
  input logic [LEN_W-1:0]  start_len,
  input logic              slot_free,
  input logic              tx_idle,
  input logic              ovr_flag,
  input logic              col_flag,
  input logic [LEN_W-1:0]  rd_len
);

  // R4
  full_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_free |-> !tx_idle);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !tx_idle);

  // R3
  zero_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && wr_len_en && wr_len_data == '0) |=> (tx_idle && !start_req));

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past((wr_addr_en || wr_len_en) && !slot_free));

  // R7
  ovr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_free && !tx_done) |=> ($stable(start_len) && $stable(start_addr) && !start_req));

  // R8
  ovr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_free && wr_addr_en && clr_ovr) |=> ovr_flag);

  // R9
  col_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_flag) |-> $past(tx_col && !tx_idle));

  // R10
  rd_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_len_en |=> $stable(rd_len));

endmodule

bind txq_ctrl txq_ctrl_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr_en(wr_addr_en), .wr_len_en(wr_len_en),
  .wr_len_data(wr_len_data), .tx_done(tx_done), .tx_col(tx_col), .clr_ovr(clr_ovr),
  .start_req(start_req), .start_addr(start_addr), .start_len(start_len),
  .slot_free(slot_free), .tx_idle(tx_idle), .ovr_flag(ovr_flag),
  .col_flag(col_flag), .rd_len(rd_len)
);

// File: tb/test_txq_ctrl.sv
module test_txq_ctrl;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_addr_en = 0, wr_len_en = 0, wr_nocrc = 0;
  logic [ADDR_W-1:0] wr_addr_data = '0;
  logic [LEN_W-1:0] wr_len_data = '0;
  logic clr_ovr = 0, clr_col = 0, tx_done = 0, tx_col = 0;
  logic start_req, start_nocrc, slot_free, tx_idle, ovr_flag, col_flag, rd_nocrc;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0] start_len, rd_len;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_txq_ctrl (.*);

  // stimulus [49]wa [48]wl [47]nocrc [46]done [45]col [44]clro [43]clrc [42:32]len [31:24]addr
  // expect  [23]sreq [22]slot_free [21]idle [20]ovr [19]colf [18:8]start_len [7:0]start_addr
  localparam int NV = 15;
  localparam logic [49:0] VEC [NV] = '{
    {7'b1000000, 11'd0,   8'h11, 5'b01100, 11'd0,   8'h00}, // R2 store address
    {7'b0100000, 11'd100, 8'h00, 5'b11000, 11'd100, 8'h11}, // R2 launch
    {7'b0000000, 11'd0,   8'h00, 5'b01000, 11'd0,   8'h00},
    {7'b1000000, 11'd0,   8'h22, 5'b01000, 11'd0,   8'h00},
    {7'b0110000, 11'd200, 8'h00, 5'b00000, 11'd0,   8'h00}, // R4 queued
    {7'b1000000, 11'd0,   8'h33, 5'b00010, 11'd0,   8'h00}, // R7 addr overrun
    {7'b0100000, 11'd300, 8'h00, 5'b00010, 11'd0,   8'h00}, // R7 len overrun
    {7'b0000100, 11'd0,   8'h00, 5'b00011, 11'd0,   8'h00}, // R9 collision
    {7'b0001000, 11'd0,   8'h00, 5'b11011, 11'd200, 8'h22}, // R5 promote
    {7'b0000011, 11'd0,   8'h00, 5'b01000, 11'd0,   8'h00}, // R8 R9 clear
    {7'b0001000, 11'd0,   8'h00, 5'b01100, 11'd0,   8'h00}, // R6 done
    {7'b0000100, 11'd0,   8'h00, 5'b01100, 11'd0,   8'h00}, // R9 idle collision
    {7'b0100000, 11'd0,   8'h00, 5'b01100, 11'd0,   8'h00}, // R3 zero length
    {7'b0100000, 11'd64,  8'h00, 5'b11000, 11'd64,  8'h22}, // R7 discarded addr unused
    {7'b0001000, 11'd0,   8'h00, 5'b01100, 11'd0,   8'h00}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in;
    wr_addr_en = 0; wr_len_en = 0; wr_nocrc = 0; tx_done = 0;
    tx_col = 0; clr_ovr = 0; clr_col = 0;
  endtask

  initial begin
    #80000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", {27'd0, start_req, slot_free, tx_idle, ovr_flag, col_flag}, 32'b01100);

    for (int i = 0; i < NV; i++) begin
      wr_addr_en   = VEC[i][49];
      wr_len_en    = VEC[i][48];
      wr_nocrc     = VEC[i][47];
      tx_done      = VEC[i][46];
      tx_col       = VEC[i][45];
      clr_ovr      = VEC[i][44];
      clr_col      = VEC[i][43];
      wr_len_data  = VEC[i][42:32];
      wr_addr_data = {24'd0, VEC[i][31:24]};
      @(negedge clk);
      chk($sformatf("row%0d flags", i),
          {27'd0, start_req, slot_free, tx_idle, ovr_flag, col_flag}, {27'd0, VEC[i][23:19]});
      if (VEC[i][23])
        chk($sformatf("row%0d start", i), {start_len, start_addr[7:0]},
            {13'd0, VEC[i][18:8], VEC[i][7:0]});
      idle_in();
    end

    // R10 rd_len kept the last accepted length, not the discarded one
    chk("R10", {21'd0, rd_len}, 32'd64);

    // R10 rd_nocrc follows the active frame
    wr_len_en = 1; wr_len_data = 11'd50; wr_nocrc = 1;
    @(negedge clk); idle_in();
    chk("R10", {31'd0, rd_nocrc}, 32'd1);
    wr_len_en = 1; wr_len_data = 11'd70; wr_nocrc = 0;
    @(negedge clk); idle_in();
    chk("R10", {20'd0, rd_nocrc, rd_len}, {20'd0, 1'b1, 11'd70});
    // R8 overrun set wins over clear in the same cycle
    wr_addr_en = 1; wr_addr_data = 32'h44; clr_ovr = 1;
    @(negedge clk); idle_in();
    chk("R8", {31'd0, ovr_flag}, 32'd1);
    clr_ovr = 1;
    @(negedge clk); idle_in();
    chk("R8", {31'd0, ovr_flag}, 32'd0);
    tx_done = 1;
    @(negedge clk); idle_in();
    // R5 R10
    chk("R5", {20'd0, start_req, start_len}, {20'd0, 1'b1, 11'd70});
    chk("R10", {31'd0, rd_nocrc}, 32'd0);
    tx_done = 1;
    @(negedge clk); idle_in();
    chk("R6", {31'd0, tx_idle}, 32'd1);
    // R6 done while idle has no effect
    tx_done = 1;
    @(negedge clk); idle_in();
    chk("R6", {29'd0, start_req, tx_idle, slot_free}, 32'b011);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule